// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a purely combinational arithmetic, logic and shift stage for a narrow datapath. It takes two operands, a 4-bit operation select and a carry input, and returns one result word and a carry output in the same cycle. No register stands between any input and any output, so the block sits between a register file read and a write-back register. A 2-bit group field picks one of four paths: arithmetic, bitwise logic, shift right by one, or shift left by one. A 2-bit sub-field and the carry input then refine the operation.

All arithmetic comes from a single ripple adder. A per-bit selector feeds the adder's second input with the operand B, its complement, all zeros or all ones. Add, add with carry, subtract, subtract with borrow, increment, decrement and pass-through all fall out of that choice together with the carry input. The width is the parameter `WIDTH`, with a default of 8.

The select is written `sel_i[3:0]`. Bits [3:2] are the group and bits [1:0] are the sub-field. In the requirements, `+` is addition modulo 2^WIDTH. `~B` is the bitwise complement of B. `ONES` is a word with every bit set.

Top module: `als_unit`

## Requirements
- R1: With sel_i = 0000, the 2^WIDTH-modulo sum A + B + cin_i appears on f_o, and the carry out of the top bit appears on cout_o.
- R2: With sel_i = 0001, f_o = A + ~B + cin_i. With cin_i = 1 this is A - B. With cin_i = 0 it is subtract with borrow. cout_o is the adder's top carry, so it is 1 for A >= B when cin_i = 1.
- R3: With sel_i = 0010, f_o = A + cin_i. This passes A when cin_i = 0 and increments A when cin_i = 1. cout_o is 1 only when A = ONES and cin_i = 1.
- R4: With sel_i = 0011, f_o = A + ONES + cin_i. This decrements A when cin_i = 0 and passes A when cin_i = 1. cout_o is 1 unless A = 0 and cin_i = 0.
- R5: With sel_i[3:2] = 01, f_o is chosen by sel_i[1:0]: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives ~A.
- R6: With sel_i[3:2] = 10, f_o is A shifted right by one position, with bit WIDTH-1 of f_o equal to 0.
- R7: With sel_i[3:2] = 11, f_o is A shifted left by one position, with bit 0 of f_o equal to 0.
- R8: cout_o is 0 whenever sel_i[3:2] is not 00, whatever the operands and cin_i are.
- R9: In the logic group, cin_i has no effect on f_o. In both shift groups, neither sel_i[1:0] nor cin_i nor B has any effect on f_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, and the only source of the shift paths |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 4 | Bits [3:2] pick the group (00 arith, 01 logic, 10 right shift, 11 left shift); bits [1:0] pick the sub-operation |
| cin_i | input | 1 | Carry into the adder's least significant bit |
| f_o | output | WIDTH | Result word |
| cout_o | output | 1 | Carry out of the adder's top bit in the arithmetic group, else 0 |

## Verification
The adder keeps computing in every cycle, so its carry and a logic or shift result are always produced together. The risk is that the carry leaks onto cout_o while a non-arithmetic group is selected. The bench provokes this with A = B = ONES and cin_i = 1, which makes the adder carry for every sub-field, and then applies each logic and shift code. It judges the result by requiring cout_o = 0 alongside the expected word. Decrement and increment wrap at the zero and all-ones boundaries in the same vectors, so the carry value in the arithmetic group is judged against the result from the bench's own model.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_SHR   = 2'b10,
    GRP_SHL   = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    Y_PLAIN = 2'b00,
    Y_INV   = 2'b01,
    Y_ZERO  = 2'b10,
    Y_ONES  = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    L_AND = 2'b00,
    L_OR  = 2'b01,
    L_XOR = 2'b10,
    L_NOT = 2'b11
  } lsel_e;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  ysel_e            ysel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] d_o,
  output logic             cout_o
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] y;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (ysel_i)
        Y_PLAIN: y[i] = b_i[i];
        Y_INV:   y[i] = ~b_i[i];
        Y_ZERO:  y[i] = 1'b0;
        default: y[i] = 1'b1;
      endcase
    end
    assign d_o[i]     = a_i[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & y[i]) | (carry[i] & (a_i[i] ^ y[i]));
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  lsel_e            lsel_i,
  output logic [WIDTH-1:0] e_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (lsel_i)
        L_AND:   e_o[i] = a_i[i] & b_i[i];
        L_OR:    e_o[i] = a_i[i] | b_i[i];
        L_XOR:   e_o[i] = a_i[i] ^ b_i[i];
        default: e_o[i] = ~a_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] shr_o,
  output logic [WIDTH-1:0] shl_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign shr_o[i] = 1'b0;
    end else begin : g_mid
      assign shr_o[i] = a_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl_o[i] = 1'b0;
    end else begin : g_up
      assign shl_o[i] = a_i[i-1];
    end
  end
endmodule

// File: rtl/als_unit.sv
module als_unit
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] f_o,
  output logic             cout_o
);
  grp_e             grp;
  logic [WIDTH-1:0] arith_d;
  logic [WIDTH-1:0] logic_e;
  logic [WIDTH-1:0] shr_v;
  logic [WIDTH-1:0] shl_v;
  logic             adder_c;

  assign grp = grp_e'(sel_i[3:2]);

  alsu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .ysel_i(ysel_e'(sel_i[1:0])),
    .cin_i (cin_i),
    .d_o   (arith_d),
    .cout_o(adder_c)
  );

  alsu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .lsel_i(lsel_e'(sel_i[1:0])),
    .e_o   (logic_e)
  );

  alsu_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i  (a_i),
    .shr_o(shr_v),
    .shl_o(shl_v)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    always_comb begin
      unique case (grp)
        GRP_ARITH: f_o[i] = arith_d[i];
        GRP_LOGIC: f_o[i] = logic_e[i];
        GRP_SHR:   f_o[i] = shr_v[i];
        default:   f_o[i] = shl_v[i];
      endcase
    end
  end

  assign cout_o = (grp == GRP_ARITH) & adder_c;
endmodule

// File: rtl/als_unit_chk.sv
module als_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       sel_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] f_o,
  input logic             cout_o
);
  logic           known;
  logic [WIDTH:0] sum_ref;

  assign known   = !$isunknown({a_i, b_i, sel_i, cin_i});
  assign sum_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    if (known) begin
      // R1
      a_r1_add_sum: assert (sel_i != 4'b0000 || {cout_o, f_o} == sum_ref)
        else $error("add mismatch");
      // R8
      a_r8_cout_low: assert (sel_i[3:2] == 2'b00 || cout_o == 1'b0)
        else $error("carry leaked");
      // R6
      a_r6_shr_fill: assert (sel_i[3:2] != 2'b10 ||
                             (f_o[WIDTH-1] == 1'b0 && f_o[WIDTH-2:0] == a_i[WIDTH-1:1]))
        else $error("right shift wrong");
      // R7
      a_r7_shl_fill: assert (sel_i[3:2] != 2'b11 ||
                             (f_o[0] == 1'b0 && f_o[WIDTH-1:1] == a_i[WIDTH-2:0]))
        else $error("left shift wrong");
      // R5
      a_r5_not_a: assert (sel_i != 4'b0111 || f_o == ~a_i)
        else $error("complement wrong");
    end
  end
endmodule

bind als_unit als_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .sel_i (sel_i),
  .cin_i (cin_i),
  .f_o   (f_o),
  .cout_o(cout_o)
);

// File: tb/test_als_unit.sv
module test_als_unit;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic [W-1:0] a, b, f;
  logic [3:0]   sel;
  logic         cin, cout;
  int           n_vec = 0;
  int           n_bad = 0;
  bit           done  = 0;

  always #2 clk = ~clk;

  als_unit #(.WIDTH(W)) i_als_unit (
    .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin), .f_o(f), .cout_o(cout)
  );

  function automatic logic [W:0] model(logic [W-1:0] xa, logic [W-1:0] xb,
                                       logic [3:0] s, logic c);
    logic [W-1:0] y;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: y = xb;
          2'b01: y = ~xb;
          2'b10: y = '0;
          default: y = ONES;
        endcase
        return {1'b0, xa} + {1'b0, y} + {{W{1'b0}}, c};
      end
      2'b01: begin
        case (s[1:0])
          2'b00: return {1'b0, xa & xb};
          2'b01: return {1'b0, xa | xb};
          2'b10: return {1'b0, xa ^ xb};
          default: return {1'b0, ~xa};
        endcase
      end
      2'b10: return {1'b0, xa >> 1};
      default: return {1'b0, xa << 1};
    endcase
  endfunction

  task automatic apply(input string tag, input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic [3:0] s, input logic c, input logic [W:0] exp);
    @(posedge clk);
    a = xa; b = xb; sel = s; cin = c;
    @(negedge clk);
    n_vec++;
    if ({cout, f} !== exp) begin
      n_bad++;
      $display("FAIL %s sel=%b cin=%b a=%h b=%h actual=%h expected=%h",
               tag, s, c, xa, xb, {cout, f}, exp);
    end
  endtask

  task automatic t_idle;
    apply("R1", '0, '0, 4'b0000, 1'b0, '0);
  endtask

  task automatic t_add;
    apply("R1", 8'h12, 8'h34, 4'b0000, 1'b0, 9'h046);
    apply("R1", 8'hFF, 8'h01, 4'b0000, 1'b0, 9'h100);
    apply("R1", 8'h7F, 8'h80, 4'b0000, 1'b1, 9'h100);
  endtask

  task automatic t_sub;
    apply("R2", 8'h50, 8'h20, 4'b0001, 1'b1, 9'h130);
    apply("R2", 8'h20, 8'h50, 4'b0001, 1'b1, 9'h0D0);
    apply("R2", 8'h50, 8'h20, 4'b0001, 1'b0, 9'h12F);
  endtask

  task automatic t_incdec;
    apply("R3", 8'h41, 8'hAA, 4'b0010, 1'b0, 9'h041);
    apply("R3", ONES,  8'h00, 4'b0010, 1'b1, 9'h100);
    apply("R4", 8'h00, 8'h33, 4'b0011, 1'b0, 9'h0FF);
    apply("R4", 8'h80, 8'h33, 4'b0011, 1'b0, 9'h17F);
    apply("R4", 8'h00, 8'h33, 4'b0011, 1'b1, 9'h100);
  endtask

  task automatic t_logic;
    apply("R5", 8'hC3, 8'hA5, 4'b0100, 1'b0, 9'h081);
    apply("R5", 8'hC3, 8'hA5, 4'b0101, 1'b0, 9'h0E7);
    apply("R5", 8'hC3, 8'hA5, 4'b0110, 1'b0, 9'h066);
    apply("R5", 8'hC3, 8'hA5, 4'b0111, 1'b0, 9'h03C);
  endtask

  task automatic t_shift;
    apply("R6", 8'h81, 8'h00, 4'b1000, 1'b0, 9'h040);
    apply("R6", ONES,  8'h00, 4'b1011, 1'b1, 9'h07F);
    apply("R7", 8'h81, 8'h00, 4'b1100, 1'b0, 9'h002);
    apply("R7", ONES,  8'h00, 4'b1110, 1'b1, 9'h0FE);
  endtask

  // R8 and R9: the adder would carry here, yet no group other than arith may show it
  task automatic t_ignored;
    for (int s = 4; s < 16; s++) begin
      for (int c = 0; c < 2; c++) begin
        apply("R8", ONES, ONES, 4'(s), 1'(c), model(ONES, ONES, 4'(s), 1'b0));
      end
    end
    for (int s = 8; s < 16; s++) begin
      apply("R9", 8'h5A, 8'h0F, 4'(s), 1'b1, model(8'h5A, 8'h00, {2'(s >> 2), 2'b00}, 1'b0));
    end
  endtask

  task automatic t_sweep;
    logic [W-1:0] ops [8];
    ops[0] = '0; ops[1] = ONES; ops[2] = 8'h80; ops[3] = 8'h7F;
    ops[4] = 8'h01; ops[5] = 8'(W'($urandom)); ops[6] = 8'(W'($urandom)); ops[7] = 8'(W'($urandom));
    for (int code = 0; code < 32; code++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          apply(code < 8 ? "R1" : "R5", ops[i], ops[j], 4'(code >> 1), 1'(code),
                model(ops[i], ops[j], 4'(code >> 1), 1'(code)));
        end
      end
    end
  endtask

  initial begin
    a = '0; b = '0; sel = '0; cin = 1'b0;
    t_idle();
    t_add();
    t_sub();
    t_incdec();
    t_logic();
    t_shift();
    t_ignored();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule